// File: doc/BRIEF.md
# Byte-wide one-time-programmable memory mode controller

This block models the control side of a small byte-wide memory that can be programmed once. Five control inputs are decoded into seven operating modes, each sampled on the clock: chip select, output gate, program strobe, a flag that says the programming supply is present, and a flag that says a high voltage sits on the identifier address line. The modes are read, output disable, standby, program, program verify, program inhibit and identifier readout. The storage array is parameterised and leaves reset fully erased, with every bit at one. A program cycle can only pull bits to zero, so each write stores the bitwise AND of the old byte and the new data.

The data bus is split into an input byte, an output byte and a drive-enable flag that a pad ring turns into a tri-state buffer. The bus is driven only after the selects have been held active for a parameterised number of clock cycles. The identifier mode returns fixed codes whose top bit makes the parity odd. Several of these blocks can share every line except chip select, and the chip select alone decides which one takes a write.

Top module: `otp_mode_ctrl`

## Requirements
- R1: After reset every byte of the array reads back as 0xFF.
- R2: `dq_oe` is high only while `chip_en_n` and `out_en_n` are both low, and it is low in every cycle in which `chip_en_n` is high, whatever `out_en_n` is.
- R3: With the output gate already held active, `dq_oe` goes high once `chip_en_n` has been low across `CE_LAT` rising clock edges, and not before.
- R4: With chip select already held active, `dq_oe` goes high once `out_en_n` has been low across `OE_LAT` rising clock edges, and not before.
- R5: `dq_oe` falls in the same cycle in which either select goes high.
- R6: A rising edge with `vpp_ok`=1, `chip_en_n`=0, `prog_n`=0 and `out_en_n`=1 stores (old byte AND `dq_in`) at `addr`. The bus is not driven in this mode.
- R7: Programming a byte that is already programmed, using data of all ones, leaves that byte unchanged.
- R8: With `vpp_ok`=1, `prog_n`=0 and `out_en_n`=1, a high `chip_en_n` blocks the write.
- R9: With `vpp_ok`=1, `prog_n`=1 and both selects low, the addressed array byte is driven (program verify). When `vpp_ok`=0 and `a9_hv`=0, the same select pattern gives a plain read.
- R10: With `a9_hv`=1, `vpp_ok`=0, both selects low and `addr[1]`=1, `addr[0]`=0 returns 0x1C and `addr[0]`=1 returns 0x01.
- R11: In identifier mode with `addr[1]`=0, both values of `addr[0]` return 0x7F.
- R12: Every identifier byte has odd parity, with bit 7 acting as the parity bit.
- R13: A low `prog_n` writes nothing when `vpp_ok`=0, or when `out_en_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| chip_en_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output gate, active low |
| prog_n | input | 1 | Program strobe, active low |
| vpp_ok | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage present on the identifier address line |
| addr | input | ADDR_W | Byte address; bits 1 and 0 select the identifier byte |
| dq_in | input | 8 | Data written during program mode |
| dq_out | output | 8 | Data presented to the bus; zero when not driving |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Several properties are checked on every cycle: that the bus never drives while either select is high or while a write is under way, that a drive never starts before the chip-select and output-gate windows have elapsed, and that any identifier byte on the bus has odd parity. Other behaviour only shows up through the scenarios. The AND-only write rule, the blocking of writes by chip select and by a missing supply, and the exact identifier values all depend on what was stored earlier or on specific addresses. These are shown by programming bytes and reading them back in verify mode, and by a reference model that is compared with the bus on every clock.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_DISABLE,
        M_READ,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT,
        M_IDENT
    } mode_e;

    // sampled control pins, active-low selects kept as-is
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic vpp;
        logic hv;
    } ctl_t;

    // request bundle produced by the decoder
    typedef struct packed {
        logic drive;   // mode wants the bus
        logic write;   // mode clears bits this edge
        logic ident;   // data comes from the code source
    } req_t;

    localparam logic [6:0] ID_MFR_PAY  = 7'h1C;
    localparam logic [6:0] ID_DEV_PAY  = 7'h01;
    localparam logic [6:0] ID_CONT_PAY = 7'h7F;

    // append a top bit that makes the total count of ones odd
    function automatic logic [BYTE_W-1:0] odd_code(input logic [6:0] pay);
        return {~(^pay), pay};
    endfunction

    function automatic mode_e decode_mode(input ctl_t c);
        mode_e m;
        if (c.ce_n) begin
            m = (c.vpp && !c.pgm_n && c.oe_n) ? M_INHIBIT : M_STANDBY;
        end else if (c.vpp) begin
            if (!c.pgm_n && c.oe_n)      m = M_PROGRAM;
            else if (c.pgm_n && !c.oe_n) m = M_VERIFY;
            else                         m = M_DISABLE;
        end else if (!c.oe_n) begin
            m = c.hv ? M_IDENT : M_READ;
        end else begin
            m = M_DISABLE;
        end
        return m;
    endfunction

    function automatic req_t mode_req(input mode_e m);
        req_t r;
        r.drive = (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
        r.write = (m == M_PROGRAM);
        r.ident = (m == M_IDENT);
        return r;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
`timescale 1ns/1ps
module otp_mode_decode
    import otp_pkg::*;
(
    input  ctl_t  ctl,
    output mode_e mode,
    output req_t  req
);
    always_comb begin
        mode = decode_mode(ctl);
        req  = mode_req(mode);
    end
endmodule

// File: rtl/otp_age_counter.sv
`timescale 1ns/1ps
module otp_age_counter #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active_n,
    output logic ready
);
    localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst || active_n) begin
            age_q <= '0;
        end else if (age_q != LIM) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign ready = (age_q == LIM);
endmodule

// File: rtl/otp_enable_timer.sv
`timescale 1ns/1ps
module otp_enable_timer #(
    parameter int CE_LAT = 3,
    parameter int OE_LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic window_ok
);
    localparam int NSEL = 2;

    logic [NSEL-1:0] sel_n;
    logic [NSEL-1:0] sel_ready;

    assign sel_n = {oe_n, ce_n};

    for (genvar g = 0; g < NSEL; g++) begin : g_age
        localparam int LAT = (g == 0) ? CE_LAT : OE_LAT;
        otp_age_counter #(.LIMIT(LAT)) u_age (
            .clk     (clk),
            .rst     (rst),
            .active_n(sel_n[g]),
            .ready   (sel_ready[g])
        );
    end

    // a select that is high right now closes the window at once
    assign window_ok = (&sel_ready) && !(|sel_n);
endmodule

// File: rtl/otp_cell_array.sv
`timescale 1ns/1ps
module otp_cell_array #(
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [otp_pkg::BYTE_W-1:0]  clr_data,
    output logic [otp_pkg::BYTE_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [otp_pkg::BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (clr_en) begin
            // only ones may become zeros
            cells[addr] <= cells[addr] & clr_data;
        end
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/otp_id_source.sv
`timescale 1ns/1ps
module otp_id_source
    import otp_pkg::*;
(
    input  logic [1:0]        sel,
    output logic [BYTE_W-1:0] code
);
    always_comb begin
        unique case (sel)
            2'b10:   code = odd_code(ID_MFR_PAY);
            2'b11:   code = odd_code(ID_DEV_PAY);
            default: code = odd_code(ID_CONT_PAY);
        endcase
    end
endmodule

// File: rtl/otp_mode_ctrl.sv
`timescale 1ns/1ps
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CE_LAT = 3,
    parameter int OE_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_n,
    input  logic              vpp_ok,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    ctl_t              ctl;
    mode_e             mode;
    req_t              req;
    logic              window_ok;
    logic [BYTE_W-1:0] cell_byte;
    logic [BYTE_W-1:0] id_byte;

    assign ctl = '{ce_n: chip_en_n, oe_n: out_en_n, pgm_n: prog_n,
                   vpp: vpp_ok, hv: a9_hv};

    otp_mode_decode u_dec (
        .ctl (ctl),
        .mode(mode),
        .req (req)
    );

    otp_enable_timer #(.CE_LAT(CE_LAT), .OE_LAT(OE_LAT)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (chip_en_n),
        .oe_n     (out_en_n),
        .window_ok(window_ok)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (req.write),
        .addr    (addr),
        .clr_data(dq_in),
        .rd_data (cell_byte)
    );

    otp_id_source u_id (
        .sel (addr[1:0]),
        .code(id_byte)
    );

    always_comb begin
        dq_oe  = req.drive && window_ok;
        dq_out = '0;
        if (dq_oe) begin
            dq_out = req.ident ? id_byte : cell_byte;
        end
    end
endmodule

// File: rtl/otp_mode_ctrl_chk.sv
`timescale 1ns/1ps
module otp_mode_ctrl_chk #(
    parameter int ADDR_W = 6,
    parameter int CE_LAT = 3,
    parameter int OE_LAT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en_n,
    input logic              out_en_n,
    input logic              prog_n,
    input logic              vpp_ok,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_in,
    input logic [7:0]        dq_out,
    input logic              dq_oe
);
    int ce_run;
    int oe_run;

    always_ff @(posedge clk) begin
        if (rst || chip_en_n) ce_run <= 0;
        else if (ce_run < 1000) ce_run <= ce_run + 1;
        if (rst || out_en_n) oe_run <= 0;
        else if (oe_run < 1000) oe_run <= oe_run + 1;
    end

    // R2
    ce_high_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |-> !dq_oe);

    // R5
    oe_high_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dq_oe);

    // R3
    ce_window_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (ce_run >= CE_LAT));

    // R4
    oe_window_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (oe_run >= OE_LAT));

    // R6
    prog_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (vpp_ok && !prog_n && !chip_en_n && out_en_n) |-> !dq_oe);

    // R12
    id_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && a9_hv && !vpp_ok) |-> (^dq_out));
endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk #(
    .ADDR_W(ADDR_W), .CE_LAT(CE_LAT), .OE_LAT(OE_LAT)
) u_chk (.*);

// File: tb/sim_otp_mode_ctrl.sv
`timescale 1ns/1ps
module sim_otp_mode_ctrl;
    localparam int ADDR_W = 6;
    localparam int CE_LAT = 3;
    localparam int OE_LAT = 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MAXL   = (CE_LAT > OE_LAT) ? CE_LAT : OE_LAT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, pg_n = 1'b1, vpp = 1'b0, hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       doe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int ref_mem [DEPTH];
    int ce_age = 0;
    int oe_age = 0;

    always #2 clk = ~clk;

    otp_mode_ctrl #(.ADDR_W(ADDR_W), .CE_LAT(CE_LAT), .OE_LAT(OE_LAT)) u0 (
        .clk(clk), .rst(rst), .chip_en_n(ce_n), .out_en_n(oe_n),
        .prog_n(pg_n), .vpp_ok(vpp), .a9_hv(hv), .addr(addr),
        .dq_in(din), .dq_out(dout), .dq_oe(doe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int id_expect(input logic [1:0] s);
        if (!s[1]) return 8'h7F;
        return s[0] ? 8'h01 : 8'h1C;
    endfunction

    // reference model, compared on every clock
    always @(posedge clk) begin
        bit exp_oe;
        int exp_d;
        if (rst) begin
            foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
            ce_age = 0;
            oe_age = 0;
        end else begin
            if (!ce_n && vpp && !pg_n && oe_n) ref_mem[addr] = ref_mem[addr] & din;
            ce_age = ce_n ? 0 : (ce_age < 1000 ? ce_age + 1 : ce_age);
            oe_age = oe_n ? 0 : (oe_age < 1000 ? oe_age + 1 : oe_age);
        end
        #1;
        if (!rst) begin
            exp_oe = !ce_n && !oe_n && ce_age >= CE_LAT && oe_age >= OE_LAT
                     && !(vpp && !pg_n);
            exp_d  = (hv && !vpp) ? id_expect(addr[1:0]) : ref_mem[addr];
            check(doe == exp_oe, "R2 model dq_oe", doe, exp_oe);
            if (exp_oe && doe) check(dout == exp_d, "R9 model dq_out", dout, exp_d);
        end
    end

    task automatic step();
        @(posedge clk);
        #1.5;
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1; oe_n = 1; pg_n = 1; vpp = 0; hv = 0;
    endtask

    task automatic rd(input int a, input bit with_vpp, input bit with_hv,
                      input int exp, input string tag);
        @(negedge clk);
        addr = a[ADDR_W-1:0]; vpp = with_vpp; hv = with_hv; pg_n = 1;
        ce_n = 0; oe_n = 0;
        repeat (MAXL) step();
        check(doe == 1'b1, tag, doe, 1);
        check(dout == exp[7:0], tag, dout, exp);
        go_idle();
    endtask

    task automatic prog(input int a, input int d, input bit cs_n);
        @(negedge clk);
        addr = a[ADDR_W-1:0]; din = d[7:0]; vpp = 1; oe_n = 1; pg_n = 0; ce_n = cs_n;
        step();
        check(doe == 1'b0, "R6 no drive in program", doe, 0);
        go_idle();
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        step();
        check(doe == 1'b0, "R2 reset idle bus", doe, 0);

        // R1 erased after reset
        rd(0, 0, 0, 8'hFF, "R1 erased byte 0");
        rd(DEPTH - 1, 0, 0, 8'hFF, "R1 erased last byte");

        // R3 chip select latency with output gate already low
        @(negedge clk); addr = 4; oe_n = 0;
        step(); step();
        @(negedge clk); ce_n = 0;
        for (int k = 1; k < CE_LAT; k++) begin
            step();
            check(doe == 1'b0, "R3 early after ce", doe, 0);
        end
        step();
        check(doe == 1'b1, "R3 drive after CE_LAT", doe, 1);
        // R5 release on gate rise, same cycle
        @(negedge clk); oe_n = 1; #0.5;
        check(doe == 1'b0, "R5 release on oe rise", doe, 0);
        // R4 gate latency with chip select held
        @(negedge clk); oe_n = 0;
        for (int k = 1; k < OE_LAT; k++) begin
            step();
            check(doe == 1'b0, "R4 early after oe", doe, 0);
        end
        step();
        check(doe == 1'b1, "R4 drive after OE_LAT", doe, 1);
        // R2 chip select high wins over output gate
        @(negedge clk); ce_n = 1; #0.5;
        check(doe == 1'b0, "R2 ce high hiz", doe, 0);
        go_idle();

        // R6 program and verify
        prog(3, 8'hA5, 0);
        rd(3, 1, 0, 8'hA5, "R6 program A5");
        prog(3, 8'h0F, 0);
        rd(3, 1, 0, 8'h05, "R6 AND with old");
        // R7 ones leave programmed byte unchanged
        prog(3, 8'hFF, 0);
        rd(3, 1, 0, 8'h05, "R7 rewrite ones");
        // R9 plain read of the same byte
        rd(3, 0, 0, 8'h05, "R9 plain read");

        // R8 inhibit via chip select high
        prog(7, 8'h00, 1);
        prog(7, 8'h00, 1);
        rd(7, 1, 0, 8'hFF, "R8 inhibited byte");

        // R13 strobe without supply
        @(negedge clk); addr = 8; din = 0; vpp = 0; ce_n = 0; oe_n = 1; pg_n = 0;
        step(); step();
        go_idle();
        rd(8, 0, 0, 8'hFF, "R13 no supply no write");
        // R13 strobe with gate low
        @(negedge clk); addr = 9; din = 0; vpp = 1; ce_n = 0; oe_n = 0; pg_n = 0;
        repeat (MAXL + 1) step();
        check(doe == 1'b0, "R13 disable bus", doe, 0);
        go_idle();
        rd(9, 1, 0, 8'hFF, "R13 gate low no write");

        // R10, R11 identifier codes
        rd(2, 0, 1, 8'h1C, "R10 maker code");
        rd(3, 0, 1, 8'h01, "R10 device code");
        rd(0, 0, 1, 8'h7F, "R11 continuation a0=0");
        rd(1, 0, 1, 8'h7F, "R11 continuation a0=1");
        // R12 parity of each code
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); addr = s[ADDR_W-1:0]; hv = 1; ce_n = 0; oe_n = 0;
            repeat (MAXL) step();
            check(doe && (^dout), "R12 odd parity", dout, id_expect(s[1:0]));
            go_idle();
        end

        step();
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule